// File: doc/BRIEF.md
# Highway and Farm-Road Crossing Light Controller

This block sequences the lamps at a crossing where a busy highway meets a lightly used farm road. The highway is the default owner of the crossing. It keeps green until a long minimum interval has passed and a vehicle is also waiting on the farm road. Each road then passes through yellow before the other road gets green. The farm road keeps green while vehicles are still arriving, but it never keeps green for less than the long interval.

Two down-counters inside the block time the intervals: a short one for yellow and a long one for green. The controller is a Mealy machine. Its timer-start pulse is asserted in the same cycle as the condition that causes a state change. That pulse reloads both counters on the same clock edge on which the state advances, so each new phase starts timing from zero. Each counter holds its expired flag until it is reloaded.

Top module: `xroad_light_ctrl`

## Requirements
- R1: While `rst_n` is low, the lamps show highway green with farm red and `tmr_start` is 0. Reset loads both counters. After reset is released, the long interval expires on the LONG_TICKS-th rising edge.
- R2: In highway green, the state holds and `tmr_start` stays 0 unless the long interval has expired and `car_waiting` is 1.
- R3: In highway green, when the long interval has expired and `car_waiting` is 1, `tmr_start` is 1 in that same cycle. The next edge moves to highway yellow.
- R4: Highway yellow lasts exactly SHORT_TICKS edges after the edge that entered it. On the last of these cycles `tmr_start` is 1, and the next edge moves to farm green. `car_waiting` has no effect during yellow.
- R5: Farm green holds while the long interval is running or `car_waiting` is 1. When the long interval has expired and `car_waiting` is 0, `tmr_start` is 1 in that cycle and the next edge moves to farm yellow.
- R6: Farm yellow lasts exactly SHORT_TICKS edges. On its last cycle `tmr_start` is 1, and the next edge returns to highway green.
- R7: Each road shows exactly one lamp. The highway shows red in both farm states, and the farm road shows red in both highway states.
- R8: The edge on which `tmr_start` is 1 reloads both counters. After the block re-enters highway green, the long interval expires again exactly LONG_TICKS edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| car_waiting | input | 1 | Farm-road vehicle sensor |
| tmr_start | output | 1 | Mealy pulse that reloads both interval counters |
| hwy_green | output | 1 | Highway green lamp |
| hwy_yellow | output | 1 | Highway yellow lamp |
| hwy_red | output | 1 | Highway red lamp |
| farm_green | output | 1 | Farm-road green lamp |
| farm_yellow | output | 1 | Farm-road yellow lamp |
| farm_red | output | 1 | Farm-road red lamp |

## Verification
The hardest case to reach is the reload timing. The long interval must restart on the edge that re-enters highway green, and not on some earlier point in the cycle. The expired flags are not visible at the ports. To reach this case, the stimulus holds `car_waiting` high through farm green until the long flag has been set for several cycles. It then releases the sensor to pass through farm yellow, and raises it again as highway green begins. The cycle on which `tmr_start` rises in the new highway green then shows directly when the long counter was reloaded. A car pulse during yellow and an idle highway well past the long interval cover the cases where an input must be ignored.

// File: rtl/xroad_light_ctrl.sv
module xroad_light_ctrl #(
  parameter int SHORT_TICKS = 4,
  parameter int LONG_TICKS  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic car_waiting,
  output logic tmr_start,
  output logic hwy_green,
  output logic hwy_yellow,
  output logic hwy_red,
  output logic farm_green,
  output logic farm_yellow,
  output logic farm_red
);
  localparam int SW = $clog2(SHORT_TICKS + 1);
  localparam int LW = $clog2(LONG_TICKS + 1);

  localparam logic [1:0] HWY_GO   = 2'b00;
  localparam logic [1:0] HWY_WARN = 2'b01;
  localparam logic [1:0] FARM_GO  = 2'b11;
  localparam logic [1:0] FARM_WARN = 2'b10;

  logic [1:0]    state, state_nx;
  logic [SW-1:0] short_cnt;
  logic [LW-1:0] long_cnt;
  logic          short_done, long_done;

  assign short_done = (short_cnt == '0);
  assign long_done  = (long_cnt == '0);

  always_comb begin
    state_nx  = state;
    tmr_start = 1'b0;
    case (state)
      HWY_GO:    if (long_done && car_waiting)  begin state_nx = HWY_WARN;  tmr_start = 1'b1; end
      HWY_WARN:  if (short_done)                begin state_nx = FARM_GO;   tmr_start = 1'b1; end
      FARM_GO:   if (long_done && !car_waiting) begin state_nx = FARM_WARN; tmr_start = 1'b1; end
      default:   if (short_done)                begin state_nx = HWY_GO;    tmr_start = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= HWY_GO;
      short_cnt <= SW'(SHORT_TICKS);
      long_cnt  <= LW'(LONG_TICKS);
    end else begin
      state <= state_nx;
      if (tmr_start) begin
        short_cnt <= SW'(SHORT_TICKS);
        long_cnt  <= LW'(LONG_TICKS);
      end else begin
        if (!short_done) short_cnt <= short_cnt - SW'(1);
        if (!long_done)  long_cnt  <= long_cnt - LW'(1);
      end
    end
  end

  assign hwy_green   = (state == HWY_GO);
  assign hwy_yellow  = (state == HWY_WARN);
  assign hwy_red     = state[1];
  assign farm_green  = (state == FARM_GO);
  assign farm_yellow = (state == FARM_WARN);
  assign farm_red    = ~state[1];
endmodule

// File: rtl/xroad_light_ctrl_chk.sv
module xroad_light_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       car_waiting,
  input logic       tmr_start,
  input logic       hwy_green,
  input logic       hwy_yellow,
  input logic       hwy_red,
  input logic       farm_green,
  input logic       farm_yellow,
  input logic       farm_red,
  input logic [1:0] state
);
  p_hwy_one_lamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({hwy_green, hwy_yellow, hwy_red}));
  p_farm_one_lamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({farm_green, farm_yellow, farm_red}));
  p_hg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hwy_green && !tmr_start |=> hwy_green);
  p_hg_needs_car_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hwy_green && tmr_start |-> car_waiting);
  p_hg_leave_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hwy_green && tmr_start |=> hwy_yellow);
  p_hy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hwy_yellow && !tmr_start |=> hwy_yellow);
  p_hy_leave_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hwy_yellow && tmr_start |=> farm_green);
  p_fg_leave_r5: assert property (@(posedge clk) disable iff (!rst_n)
    farm_green && tmr_start |-> !car_waiting);
  p_fg_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    farm_green && tmr_start |=> farm_yellow);
  p_fy_leave_r6: assert property (@(posedge clk) disable iff (!rst_n)
    farm_yellow && tmr_start |=> hwy_green);
  p_gray_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state ^ $past(state)) <= 1);
endmodule

bind xroad_light_ctrl xroad_light_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .car_waiting(car_waiting), .tmr_start(tmr_start),
  .hwy_green(hwy_green), .hwy_yellow(hwy_yellow), .hwy_red(hwy_red),
  .farm_green(farm_green), .farm_yellow(farm_yellow), .farm_red(farm_red),
  .state(state)
);

// File: tb/xroad_light_ctrl_test.sv
`timescale 1ns/1ps
module xroad_light_ctrl_test;
  localparam int S = 3;
  localparam int L = 6;
  localparam logic [5:0] HG = 6'b100_001;
  localparam logic [5:0] HY = 6'b010_001;
  localparam logic [5:0] FG = 6'b001_100;
  localparam logic [5:0] FY = 6'b001_010;

  logic clk = 1'b0, rst_n = 1'b0, car_waiting = 1'b0;
  logic tmr_start, hg, hy, hr, fg, fy, fr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xroad_light_ctrl #(.SHORT_TICKS(S), .LONG_TICKS(L)) uut (
    .clk(clk), .rst_n(rst_n), .car_waiting(car_waiting), .tmr_start(tmr_start),
    .hwy_green(hg), .hwy_yellow(hy), .hwy_red(hr),
    .farm_green(fg), .farm_yellow(fy), .farm_red(fr));

  function automatic logic [5:0] lamps();
    return {hg, hy, hr, fg, fy, fr};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic expect_at(input string req, input logic [5:0] lv, input logic st);
    check(req, lamps(), lv);
    check(req, {5'd0, tmr_start}, {5'd0, st});
    check({req, "/R7"}, {4'd0, ($countones({hg, hy, hr}) == 1), ($countones({fg, fy, fr}) == 1)}, 6'b11);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; car_waiting = 1'b0;
    repeat (3) @(negedge clk);
    #1 expect_at("R1 reset state", HG, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_idle_highway();
    for (int k = 1; k <= L + 4; k++) begin
      @(negedge clk); #1;
      expect_at("R2 no car keeps highway green", HG, 1'b0);
    end
  endtask

  task automatic t_car_to_yellow();
    car_waiting = 1'b1; #1;
    expect_at("R3 car after long interval pulses start", HG, 1'b1);
    @(negedge clk); #1;
    expect_at("R3 moved to highway yellow", HY, 1'b0);
    for (int j = 1; j <= S; j++) begin
      if (j == 1) car_waiting = 1'b0;
      if (j == 2) car_waiting = 1'b1;
      @(negedge clk); #1;
      expect_at("R4 yellow length and car ignored", HY, (j == S));
    end
    @(negedge clk); #1;
    expect_at("R4 moved to farm green", FG, 1'b0);
  endtask

  task automatic t_farm_cycle();
    for (int k = 1; k <= L + 3; k++) begin
      @(negedge clk); #1;
      expect_at("R5 farm green held by car", FG, 1'b0);
    end
    car_waiting = 1'b0; #1;
    expect_at("R5 no car ends farm green", FG, 1'b1);
    @(negedge clk); #1;
    expect_at("R5 moved to farm yellow", FY, 1'b0);
    for (int j = 1; j <= S; j++) begin
      if (j == S) car_waiting = 1'b1;
      @(negedge clk); #1;
      expect_at("R6 farm yellow length", FY, (j == S));
    end
    @(negedge clk); #1;
    expect_at("R6 back to highway green", HG, 1'b0);
  endtask

  task automatic t_reload();
    for (int j = 1; j <= L; j++) begin
      @(negedge clk); #1;
      expect_at("R8 long interval reloaded on reentry", HG, (j == L));
    end
    @(negedge clk); #1;
    expect_at("R8 leaves after reloaded interval", HY, 1'b0);
  endtask

  initial begin
    t_reset();
    t_idle_highway();
    t_car_to_yellow();
    t_farm_cycle();
    t_reload();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule